// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute stage of a load-store RISC core. It is purely combinational: within the same cycle it turns two 32-bit register operands, an optional 16-bit immediate, a 5-bit constant shift amount and an operation code into a 32-bit result and an overflow-trap flag. The instruction decoder selects the operation and says whether operand B comes from the register file or from the immediate. When it comes from the immediate, the decoder also says whether to sign-extend it (arithmetic class, including the non-trapping add-immediate) or to zero-extend it (logical class).

The trapping add and subtract raise `ovf_o` on two's-complement overflow. In that case `wb_en_o` drops, so the pipeline leaves the destination register untouched and hands control to the trap logic outside this block. Every other operation, including the non-trapping add and subtract, keeps `ovf_o` low and `wb_en_o` high.

Operation codes on `op_i`: 0 ADD (trapping), 1 ADDU, 2 SUB (trapping), 3 SUBU, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 SLT, 9 SLTU, 10 SLL, 11 SRL, 12 SRA, 13 SLLV, 14 SRLV, 15 SRAV, 16 LUI. Codes 17 to 31 are unused.

Top module: `risc_alu`

## Requirements
- R1: For ADD (code 0) and SUB (code 2) the result is A+B or A-B modulo 2^32, and `ovf_o` is 1 exactly when the true signed result lies outside -2^31 to 2^31-1.
- R2: ADDU (code 1) and SUBU (code 3) give the same wrapped result as ADD and SUB, and `ovf_o` stays 0 for every pair of operands.
- R3: `ovf_o` is 0 for every code other than 0 and 2, whatever the operand values.
- R4: `wb_en_o` is the inverse of `ovf_o`: it is 0 only when a trapping operation overflows.
- R5: When `src_imm_i` is 1, operand B is `imm_i` sign-extended if `imm_sext_i` is 1 and zero-extended if it is 0. `opb_i` then has no effect on the result.
- R6: AND (4), OR (5) and XOR (6) are bitwise, and NOR (7) returns ~(A | B).
- R7: SLT (8) returns 1 when A < B as two's-complement numbers and 0 otherwise. Bits 31:1 are always 0.
- R8: SLTU (9) returns 1 when A < B as unsigned numbers and 0 otherwise.
- R9: SLL (10), SRL (11) and SRA (12) shift `opb_i` by `shamt_i`. The logical shifts fill with zeros. SRA fills with bit 31 of `opb_i`.
- R10: SLLV (13), SRLV (14) and SRAV (15) shift `opb_i` by `opa_i[4:0]`. Bits 31:5 of `opa_i` have no effect.
- R11: LUI (16) returns `{imm_i, 16'h0000}` regardless of the operands.
- R12: Unused codes 17 to 31 return a zero result with `ovf_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code (see list above) |
| opa_i | input | 32 | Operand A (register source; shift count for variable shifts) |
| opb_i | input | 32 | Operand B from the register file; value to shift |
| imm_i | input | 16 | Instruction immediate |
| src_imm_i | input | 1 | 1 selects the extended immediate as operand B |
| imm_sext_i | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| shamt_i | input | 5 | Constant shift amount |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow on a trapping add or subtract |
| wb_en_o | output | 1 | Result may be written back |

## Verification
The hardest cases to reach are the overflow boundaries. Uniform random operands give signed overflow about a quarter of the time, but they almost never land exactly on the most positive or most negative value, where one step more or less decides the trap. The stimulus therefore adds directed pairs: 0x7FFFFFFF plus 1, 0x80000000 minus 1, 0x80000000 minus 0x80000000, and a sign-extended immediate of -1 added to the minimum value. The random phase draws operands from a small set of edge values half of the time, so these boundaries recur alongside fully random words.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLT  = 5'd8,
        OP_SLTU = 5'd9,
        OP_SLL  = 5'd10,
        OP_SRL  = 5'd11,
        OP_SRA  = 5'd12,
        OP_SLLV = 5'd13,
        OP_SRLV = 5'd14,
        OP_SRAV = 5'd15,
        OP_LUI  = 5'd16
    } alu_op_e;

    function automatic logic op_traps(input logic [4:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  reg_b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             sext_i,
    output logic [XLEN-1:0]  opnd_o
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [EXT_W-1:0] fill;
    logic [XLEN-1:0]  imm_ext;

    always_comb begin
        fill    = sext_i ? {EXT_W{imm_i[IMM_W-1]}} : {EXT_W{1'b0}};
        imm_ext = {fill, imm_i};
        opnd_o  = use_imm_i ? imm_ext : reg_b_i;
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            ovf_o,
    output logic            lt_s_o,
    output logic            lt_u_o
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_x;
    logic [XLEN:0]   wide;

    always_comb begin
        b_x   = sub_i ? ~b_i : b_i;
        wide  = {1'b0, a_i} + {1'b0, b_x} + {{XLEN{1'b0}}, sub_i};
        sum_o = wide[MSB:0];
        // operands of equal sign producing a result of the other sign
        ovf_o = (a_i[MSB] == b_x[MSB]) && (wide[MSB] != a_i[MSB]);
        // valid when sub_i is set
        lt_s_o = wide[MSB] ^ ovf_o;
        lt_u_o = ~wide[XLEN];
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         data_i,
    input  logic [$clog2(XLEN)-1:0] amt_i,
    input  logic                    left_i,
    input  logic                    arith_i,
    output logic [XLEN-1:0]         data_o
);
    localparam int SHW = $clog2(XLEN);

    logic [XLEN-1:0] stage [SHW+1];
    logic            fill;

    assign fill     = arith_i & data_i[XLEN-1];
    assign stage[0] = data_i;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int K = 1 << s;
        logic [XLEN-1:0] moved;
        always_comb begin
            if (left_i) begin
                moved = {stage[s][XLEN-1-K:0], {K{1'b0}}};
            end else begin
                moved = {{K{fill}}, stage[s][XLEN-1:K]};
            end
        end
        assign stage[s+1] = amt_i[s] ? moved : stage[s];
    end

    assign data_o = stage[SHW];
endmodule

// File: rtl/risc_alu.sv
module risc_alu #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [4:0]              op_i,
    input  logic [XLEN-1:0]         opa_i,
    input  logic [XLEN-1:0]         opb_i,
    input  logic [IMM_W-1:0]        imm_i,
    input  logic                    src_imm_i,
    input  logic                    imm_sext_i,
    input  logic [$clog2(XLEN)-1:0] shamt_i,
    output logic [XLEN-1:0]         result_o,
    output logic                    ovf_o,
    output logic                    wb_en_o
);
    import alu_pkg::*;

    localparam int SHW = $clog2(XLEN);
    localparam int LOW = XLEN - IMM_W;

    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] sum;
    logic            add_ovf;
    logic            lt_s;
    logic            lt_u;
    logic            do_sub;
    logic [SHW-1:0]  sh_amt;
    logic            sh_left;
    logic            sh_arith;
    logic [XLEN-1:0] sh_out;
    logic [XLEN-1:0] res_d;
    logic            ovf_d;

    alu_opnd_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
        .reg_b_i   (opb_i),
        .imm_i     (imm_i),
        .use_imm_i (src_imm_i),
        .sext_i    (imm_sext_i),
        .opnd_o    (opnd_b)
    );

    always_comb begin
        do_sub = (op_i == OP_SUB) || (op_i == OP_SUBU) ||
                 (op_i == OP_SLT) || (op_i == OP_SLTU);
        sh_amt = ((op_i == OP_SLLV) || (op_i == OP_SRLV) || (op_i == OP_SRAV))
                 ? opa_i[SHW-1:0] : shamt_i;
        sh_left  = (op_i == OP_SLL) || (op_i == OP_SLLV);
        sh_arith = (op_i == OP_SRA) || (op_i == OP_SRAV);
    end

    alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a_i    (opa_i),
        .b_i    (opnd_b),
        .sub_i  (do_sub),
        .sum_o  (sum),
        .ovf_o  (add_ovf),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    alu_shift #(.XLEN(XLEN)) u_shift (
        .data_i  (opb_i),
        .amt_i   (sh_amt),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .data_o  (sh_out)
    );

    always_comb begin
        res_d = '0;
        ovf_d = 1'b0;
        case (op_i)
            OP_ADD, OP_SUB: begin
                res_d = sum;
                ovf_d = add_ovf;
            end
            OP_ADDU, OP_SUBU: res_d = sum;
            OP_AND:  res_d = opa_i & opnd_b;
            OP_OR:   res_d = opa_i | opnd_b;
            OP_XOR:  res_d = opa_i ^ opnd_b;
            OP_NOR:  res_d = ~(opa_i | opnd_b);
            OP_SLT:  res_d = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: res_d = {{(XLEN-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV: res_d = sh_out;
            OP_LUI:  res_d = {imm_i, {LOW{1'b0}}};
            default: begin
                res_d = '0;
                ovf_d = 1'b0;
            end
        endcase
    end

    assign result_o = res_d;
    assign ovf_o    = ovf_d;
    assign wb_en_o  = ~ovf_d;
endmodule

// File: rtl/risc_alu_checker.sv
module risc_alu_checker #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input logic [4:0]              op_i,
    input logic [XLEN-1:0]         opa_i,
    input logic [XLEN-1:0]         opb_i,
    input logic                    src_imm_i,
    input logic [$clog2(XLEN)-1:0] shamt_i,
    input logic [XLEN-1:0]         result_o,
    input logic                    ovf_o,
    input logic                    wb_en_o
);
    import alu_pkg::*;
    localparam int MSB = XLEN - 1;
    localparam int LOW = XLEN - IMM_W;

    always_comb begin
        if (!op_traps(op_i)) begin
            assert_no_overflow_R3: assert (!ovf_o);
        end
        if (ovf_o) begin
            assert_no_writeback_R4: assert (!wb_en_o);
        end
        if (op_i == OP_ADD && !src_imm_i && opa_i[MSB] == opb_i[MSB]
            && result_o[MSB] != opa_i[MSB]) begin
            assert_add_traps_R1: assert (ovf_o);
        end
        if (op_i == OP_SLT || op_i == OP_SLTU) begin
            assert_compare_bool_R7: assert (result_o[MSB:1] == '0);
        end
        if (op_i == OP_SRA && opb_i[MSB]) begin
            assert_sra_sign_R9: assert (result_o[MSB]);
        end
        if (op_i == OP_LUI) begin
            assert_lui_low_R11: assert (result_o[LOW-1:0] == '0);
        end
        if (op_i > OP_LUI) begin
            assert_unused_zero_R12: assert (result_o == '0 && !ovf_o);
        end
        if (op_i == OP_SLL && shamt_i != '0) begin
            assert_sll_zero_fill_R9: assert (!result_o[0]);
        end
    end
endmodule

bind risc_alu risc_alu_checker #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
    .op_i      (op_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .src_imm_i (src_imm_i),
    .shamt_i   (shamt_i),
    .result_o  (result_o),
    .ovf_o     (ovf_o),
    .wb_en_o   (wb_en_o)
);

// File: tb/risc_alu_bench.sv
module risc_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op;
    logic [31:0] opa, opb;
    logic [15:0] imm;
    logic        src_imm, imm_sext;
    logic [4:0]  shamt;
    logic [31:0] result;
    logic        ovf, wb_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    risc_alu u_risc_alu (
        .op_i(op), .opa_i(opa), .opb_i(opb), .imm_i(imm),
        .src_imm_i(src_imm), .imm_sext_i(imm_sext), .shamt_i(shamt),
        .result_o(result), .ovf_o(ovf), .wb_en_o(wb_en)
    );

    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'd0, 5'd2: return "R1";
            5'd1, 5'd3: return "R2";
            5'd4, 5'd5, 5'd6, 5'd7: return "R6";
            5'd8: return "R7";
            5'd9: return "R8";
            5'd10, 5'd11, 5'd12: return "R9";
            5'd13, 5'd14, 5'd15: return "R10";
            5'd16: return "R11";
            default: return "R12";
        endcase
    endfunction

    // reference model written from the requirements
    task automatic model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic si, input logic se,
                         input logic [4:0] sh, output logic [31:0] r, output logic v);
        logic [31:0] be;
        longint sa, sb, s;
        be = si ? (se ? {{16{im[15]}}, im} : {16'h0, im}) : b;
        sa = longint'($signed(a));
        sb = longint'($signed(be));
        r = 32'h0;
        v = 1'b0;
        case (o)
            5'd0: begin s = sa + sb; r = a + be; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            5'd2: begin s = sa - sb; r = a - be; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            5'd1: r = a + be;
            5'd3: r = a - be;
            5'd4: r = a & be;
            5'd5: r = a | be;
            5'd6: r = a ^ be;
            5'd7: r = ~(a | be);
            5'd8: r = (sa < sb) ? 32'd1 : 32'd0;
            5'd9: r = (a < be) ? 32'd1 : 32'd0;
            5'd10: r = b << sh;
            5'd11: r = b >> sh;
            5'd12: r = $unsigned($signed(b) >>> sh);
            5'd13: r = b << a[4:0];
            5'd14: r = b >> a[4:0];
            5'd15: r = $unsigned($signed(b) >>> a[4:0]);
            5'd16: r = {im, 16'h0};
            default: r = 32'h0;
        endcase
    endtask

    task automatic check(input string tag, input logic [4:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] im, input logic si,
                         input logic se, input logic [4:0] sh);
        logic [31:0] er;
        logic ev;
        @(posedge clk);
        #1;
        op = o; opa = a; opb = b; imm = im; src_imm = si; imm_sext = se; shamt = sh;
        model(o, a, b, im, si, se, sh, er, ev);
        @(negedge clk);
        n_cmp++;
        if (result !== er || ovf !== ev || wb_en !== ~ev) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h: got res=%h ovf=%b wb=%b, expected res=%h ovf=%b wb=%b",
                     tag, o, a, b, im, result, ovf, wb_en, er, ev, ~ev);
        end
    endtask

    function automatic logic [31:0] pick(input logic [31:0] rnd, input logic [2:0] sel);
        case (sel)
            3'd0: return 32'h7FFF_FFFF;
            3'd1: return 32'h8000_0000;
            3'd2: return 32'hFFFF_FFFF;
            3'd3: return 32'h0000_0000;
            default: return rnd;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        op = 5'd0; opa = '0; opb = '0; imm = '0; src_imm = 1'b0; imm_sext = 1'b0; shamt = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 idle inputs give zero, no trap (R4 wb high)
        check("R1", 5'd0, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, 5'd0);
        // R1 overflow boundaries
        check("R1", 5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        check("R1", 5'd2, 32'h8000_0000, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        check("R1", 5'd2, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0, 1'b0, 5'd0);
        check("R1", 5'd2, 32'h0, 32'h8000_0000, 16'h0, 1'b0, 1'b0, 5'd0);
        check("R4", 5'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0, 1'b0, 5'd0);
        // R2 no trap on wrap
        check("R2", 5'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        check("R2", 5'd3, 32'h8000_0000, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        // R5 immediate extension, opb ignored
        check("R5", 5'd0, 32'h8000_0000, 32'h1234_5678, 16'hFFFF, 1'b1, 1'b1, 5'd0);
        check("R5", 5'd1, 32'h0000_0001, 32'hDEAD_BEEF, 16'h8000, 1'b1, 1'b1, 5'd0);
        check("R5", 5'd5, 32'h0000_0000, 32'hFFFF_FFFF, 16'h8001, 1'b1, 1'b0, 5'd0);
        // R6 NOR
        check("R6", 5'd7, 32'hF0F0_0000, 32'h0F00_0001, 16'h0, 1'b0, 1'b0, 5'd0);
        // R7 / R8 signed vs unsigned
        check("R7", 5'd8, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        check("R8", 5'd9, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, 5'd0);
        check("R7", 5'd8, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, 1'b0, 5'd0);
        check("R8", 5'd9, 32'h5, 32'h5, 16'h0, 1'b0, 1'b0, 5'd0);
        // R9 shifts by constant
        check("R9", 5'd12, 32'h0, 32'h8000_0010, 16'h0, 1'b0, 1'b0, 5'd31);
        check("R9", 5'd11, 32'h0, 32'h8000_0010, 16'h0, 1'b0, 1'b0, 5'd4);
        check("R9", 5'd10, 32'h0, 32'h8000_0011, 16'h0, 1'b0, 1'b0, 5'd1);
        // R10 upper bits of opa ignored
        check("R10", 5'd15, 32'hFFFF_FFE3, 32'h9000_0000, 16'h0, 1'b0, 1'b0, 5'd0);
        check("R10", 5'd13, 32'h0000_0120, 32'h0000_0001, 16'h0, 1'b0, 1'b0, 5'd7);
        // R11 LUI
        check("R11", 5'd16, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 1'b0, 1'b0, 5'd3);
        // R12 unused code
        check("R12", 5'd31, 32'h7FFF_FFFF, 32'h1, 16'hFFFF, 1'b0, 1'b0, 5'd5);
        check("R12", 5'd17, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0, 1'b0, 5'd0);
        // R3 and all: constrained random
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  o;
            logic [31:0] a, b;
            logic [31:0] r0;
            o = 5'($urandom_range(0, 18));
            r0 = $urandom;
            a = pick(r0, 3'($urandom_range(0, 7)));
            r0 = $urandom;
            b = pick(r0, 3'($urandom_range(0, 7)));
            check(req_of(o), o, a, b, 16'($urandom), 1'($urandom), 1'($urandom), 5'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule